// File: doc/BRIEF.md
# Dual-Edge Timestamp Tick Counter

This block turns a free-running 32768 Hz square wave from an external timekeeping oscillator into a timebase with a resolution of 1/65536 s. No frequency multiplier is involved. The slow input is brought into the fast system clock domain through a synchronizer. Every level change counts as one tick, whether the input rises or falls. With a 50% duty cycle, the ticks therefore arrive evenly at 65536 Hz.

Each tick advances a 16-bit sub-second field. When that field rolls over, a seconds counter advances and a one-cycle pulse marks the new second. The sub-second field is presented as the timestamp word. While the timebase is disabled, the word carries a reserved null code instead. Downstream logic treats that code as "no timestamp here", so another source can fill the field later. The counter keeps running underneath the null code, so enabling the output again loses no time.

Top module: `tsc_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the sub-second count and the seconds count to zero and holds both pulse outputs low.
- R2: A rising edge of `oscIn` advances the sub-second count by exactly one. The new value appears after the third rising clock edge that follows the input change.
- R3: A falling edge of `oscIn` advances the sub-second count by exactly one, with the same latency as in R2.
- R4: `tickPulse` is high for exactly the one cycle in which the count shows its advanced value.
- R5: While `oscIn` holds its level, the count, the seconds value and both pulses do not change.
- R6: When a tick moves the sub-second count from 0xFFFF to 0x0000, `seconds` increases by one and `secondPulse` is high for that one cycle only.
- R7: While `tsEnable` is low, `timestamp` reads the null code, which has the MSB set and all other bits clear (0x8000 at 16 bits). Ticks are still counted, so `timestamp` shows the full count as soon as `tsEnable` returns high.
- R8: If `oscIn` is already high when reset is released, no tick is produced. Only a real level change counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| oscIn | input | 1 | 32768 Hz square wave, asynchronous to clk |
| tsEnable | input | 1 | High: show the count; low: show the null code |
| timestamp | output | FRAC_W (16) | Sub-second count, or the null code |
| seconds | output | SEC_W (32) | Whole seconds elapsed since reset |
| tickPulse | output | 1 | One-cycle strobe for each counted input edge |
| secondPulse | output | 1 | One-cycle strobe when the sub-second count wraps |

## Verification
A level change on `oscIn` that is set up before clock edge k is captured by the first synchronizer flop at edge k. It reaches the second flop at edge k+1. It is compared against the previous sample and counted at edge k+2. At that same edge k+2, `timestamp`, `tickPulse`, `secondPulse` and `seconds` all change together.

The reference model in the bench keeps the input samples taken at the last three edges. It applies the increment at the edge where the samples from two and three edges back differ. The bench compares the model with every output at each falling clock edge, midway between rising edges.

`timestamp` also depends on `tsEnable` with no clock delay. Inputs are therefore changed only shortly after a rising edge, so the following falling-edge compare sees the new enable state.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  // Strobes passed from the edge-detect control to the counting datapath
  typedef struct packed {
    logic clear;    // synchronous clear of all counters
    logic advance;  // one detected level change of the slow input
  } tsStrobe_t;
endpackage

// File: rtl/tsc_ctrl.sv
module tsc_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               oscIn,
  output tsc_pkg::tsStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;
  logic          prevLevel;

  // Synchronizer flops are never reset; they only sample
  always_ff @(posedge clk) begin
    syncChain[0] <= oscIn;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  // Tracks the synchronized level during reset too, so release makes no edge
  always_ff @(posedge clk) begin
    prevLevel <= syncChain[LAST];
  end

  always_comb begin
    strobe.clear   = rst;
    strobe.advance = !rst && (syncChain[LAST] ^ prevLevel);
  end
endmodule

// File: rtl/tsc_datapath.sv
module tsc_datapath #(
  parameter int FRAC_W = 16,
  parameter int SEC_W  = 32
) (
  input  logic               clk,
  input  tsc_pkg::tsStrobe_t strobe,
  output logic [FRAC_W-1:0]  subCount,
  output logic [SEC_W-1:0]   secCount,
  output logic               tickOut,
  output logic               secOut
);
  localparam logic [FRAC_W-1:0] FRAC_MAX = '1;

  logic atTop;
  assign atTop = (subCount == FRAC_MAX);

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      subCount <= '0;
      secCount <= '0;
      tickOut  <= 1'b0;
      secOut   <= 1'b0;
    end else begin
      tickOut <= strobe.advance;
      secOut  <= strobe.advance && atTop;
      if (strobe.advance) begin
        subCount <= subCount + 1'b1;
        if (atTop) secCount <= secCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsc_top.sv
module tsc_top #(
  parameter int FRAC_W      = 16,
  parameter int SEC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              oscIn,
  input  logic              tsEnable,
  output logic [FRAC_W-1:0] timestamp,
  output logic [SEC_W-1:0]  seconds,
  output logic              tickPulse,
  output logic              secondPulse
);
  localparam logic [FRAC_W-1:0] NULL_CODE = {1'b1, {(FRAC_W-1){1'b0}}};

  tsc_pkg::tsStrobe_t strobe;
  logic [FRAC_W-1:0]  subCount;

  tsc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .oscIn  (oscIn),
    .strobe (strobe)
  );

  tsc_datapath #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .subCount (subCount),
    .secCount (seconds),
    .tickOut  (tickPulse),
    .secOut   (secondPulse)
  );

  assign timestamp = tsEnable ? subCount : NULL_CODE;
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker #(
  parameter int FRAC_W = 16,
  parameter int SEC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              tsEnable,
  input logic [FRAC_W-1:0] timestamp,
  input logic [FRAC_W-1:0] subCount,
  input logic [SEC_W-1:0]  seconds,
  input logic              tickPulse,
  input logic              secondPulse
);
  localparam logic [FRAC_W-1:0] NULL_V = {1'b1, {(FRAC_W-1){1'b0}}};

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (subCount == '0 && seconds == '0 && !tickPulse && !secondPulse));

  // R4
  a_r4_tick_steps_one: assert property (@(posedge clk) disable iff (rst)
    tickPulse |-> subCount == $past(subCount) + 1'b1);

  // R5
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!tickPulse && !$past(rst)) |-> ($stable(subCount) && $stable(seconds)));

  // R6
  a_r6_wrap_carries: assert property (@(posedge clk) disable iff (rst)
    secondPulse |-> (tickPulse && subCount == '0 && seconds == $past(seconds) + 1'b1));

  // R6
  a_r6_second_single: assert property (@(posedge clk) disable iff (rst)
    secondPulse |=> !secondPulse);

  // R7
  a_r7_null_when_off: assert property (@(posedge clk) disable iff (rst)
    !tsEnable |-> timestamp == NULL_V);
endmodule

bind tsc_top tsc_checker #(.FRAC_W(FRAC_W), .SEC_W(SEC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tsEnable    (tsEnable),
  .timestamp   (timestamp),
  .subCount    (subCount),
  .seconds     (seconds),
  .tickPulse   (tickPulse),
  .secondPulse (secondPulse)
);

// File: tb/sim_tsc_top.sv
`timescale 1ns/1ps
module sim_tsc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        oscIn = 1'b1;
  logic        tsEnable = 1'b1;
  logic [15:0] timestamp;
  logic [31:0] seconds;
  logic        tickPulse, secondPulse;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // reference model state
  bit  d1 = 1'b1, d2 = 1'b1, d3 = 1'b1;
  int  mCount = 0;
  int  mSec = 0;
  bit  mTick = 1'b0, mSecP = 1'b0;
  int  secPulsesSeen = 0;

  always #4 clk = ~clk;

  tsc_top u0 (
    .clk(clk), .rst(rst), .oscIn(oscIn), .tsEnable(tsEnable),
    .timestamp(timestamp), .seconds(seconds),
    .tickPulse(tickPulse), .secondPulse(secondPulse)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural model: a change between samples two and three edges back counts
  always @(posedge clk) begin
    bit inc;
    inc = (d2 != d3);
    if (rst) begin
      mCount = 0; mSec = 0; mTick = 0; mSecP = 0;
    end else begin
      mTick = inc;
      mSecP = inc && (mCount == 65535);
      if (inc) begin
        if (mCount == 65535) begin
          mCount = 0;
          mSec++;
        end else mCount++;
      end
    end
    d3 = d2; d2 = d1; d1 = oscIn;
  end

  // Compare every cycle, midway between rising edges
  always @(negedge clk) begin
    longint expTs;
    if (!finished) begin
      expTs = tsEnable ? mCount : 16'h8000;
      check(timestamp == expTs, "R2 timestamp", timestamp, expTs);
      check(tickPulse == mTick, "R4 tickPulse", tickPulse, mTick);
      check(secondPulse == mSecP, "R6 secondPulse", secondPulse, mSecP);
      check(seconds == mSec, "R6 seconds", seconds, mSec);
      if (secondPulse) secPulsesSeen++;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(6);
    rst = 1'b0;
    step(1);
    // R1: reset state
    @(negedge clk);
    check(timestamp == 0 && seconds == 0, "R1 reset clears", timestamp, 0);
    check(!tickPulse && !secondPulse, "R1 pulses low", tickPulse, 0);
    step(10);
    // R8: input high at release, no tick
    @(negedge clk);
    check(timestamp == 0, "R8 no spurious tick", timestamp, 0);

    // R3: falling edge; counted after the third edge
    oscIn = 1'b0;
    step(2);
    @(negedge clk);
    check(timestamp == 0, "R3 not yet (latency)", timestamp, 0);
    step(1);
    @(negedge clk);
    check(timestamp == 1 && tickPulse, "R3 fall counts", timestamp, 1);
    step(4);
    // R2: rising edge
    oscIn = 1'b1;
    step(3);
    @(negedge clk);
    check(timestamp == 2, "R2 rise counts", timestamp, 2);
    step(1);
    @(negedge clk);
    check(!tickPulse, "R4 single cycle", tickPulse, 0);

    // R5: steady input
    step(20);
    @(negedge clk);
    check(timestamp == 2 && !tickPulse, "R5 steady hold", timestamp, 2);

    // R7: null code while disabled, count continues
    tsEnable = 1'b0;
    for (int i = 0; i < 4; i++) begin
      oscIn = ~oscIn;
      step(5);
    end
    @(negedge clk);
    check(timestamp == 16'h8000, "R7 null code", timestamp, 16'h8000);
    tsEnable = 1'b1;
    step(1);
    @(negedge clk);
    check(timestamp == 6, "R7 count kept", timestamp, 6);

    // R6: run fast to the wrap
    for (int i = 0; i < 65540; i++) begin
      oscIn = ~oscIn;
      step(2);
    end
    step(6);
    @(negedge clk);
    check(seconds == 1, "R6 seconds advanced", seconds, 1);
    check(secPulsesSeen == 1, "R6 one second pulse", secPulsesSeen, 1);
    check(timestamp == 10, "R6 wrapped count", timestamp, 10);

    // R1: reset mid-run
    rst = 1'b1;
    step(4);
    rst = 1'b0;
    step(1);
    @(negedge clk);
    check(timestamp == 0 && seconds == 0, "R1 reset mid-run", seconds, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule